// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data cache

This block is the lookup path of a direct-mapped level-one data cache whose set index and word select are drawn only from address bits that translation leaves unchanged. A request presents a virtual byte address. In the cycle the request is accepted, the tag, valid and data arrays are read while the translation buffer looks up the page. In the following cycle the translation result (a hit flag and a physical page number) arrives. The stored physical tag is then compared against the tag formed from that page number. Because the index never depends on translated bits, every virtual alias of one physical word lands in the same set and finds the same copy.

A read hit returns the word in the compare cycle. A read miss issues a one-cycle line request to the next level with the line-aligned physical address, then accepts the line one word per beat in ascending order. It writes the line and tag, marks the set valid, and responds in the cycle after the last beat. Writes go straight through to the next level with their physical address. A write hit also updates the cached word, and a write miss allocates nothing. A stalled translation holds the lookup in place. An invalidate-all input, like reset, clears every valid bit.

Top module: `vipt_l1_cache`

## Requirements
- R1: After reset, and in the cycle after `inval_all` is high, no set is valid, so the next read of any address misses.
- R2: The set is virtual address bits [12:6] and the word within the line is bits [5:2]. Arrays are read in the accept cycle (`req_valid` and `req_ready` both high) and compared in the next cycle.
- R3: While a lookup is pending and `tlb_hit` is low, the block holds the lookup and keeps `resp_valid`, `fill_req`, `wt_valid` and `req_ready` low.
- R4: A read whose stored valid tag equals the translated page number gives `resp_valid`=1, `resp_hit`=1 and the cached word in the cycle `tlb_hit` is high.
- R5: Two virtual addresses with equal bits [12:0] that translate to the same page number hit the same cached line.
- R6: A read miss raises `fill_req` for exactly one cycle, in the cycle after the compare, with `fill_paddr` = {page number, virtual bits [12:6], 6'b0}.
- R7: Refill takes 16 beats on `fill_beat_valid`, word 0 first. In the cycle after the last beat, `resp_valid`=1, `resp_hit`=0 and `resp_rdata` is the requested word of the line. No request is accepted and no response is given while beats are being taken. The line is then valid.
- R8: A write gives, in its compare cycle, `wt_valid`=1 with `wt_paddr` = {page number, virtual bits [12:0]} and `wt_wdata`, together with `resp_valid`=1. `resp_hit` reports the tag match. A write hit updates the cached word, and a write miss leaves the cache contents unchanged.
- R9: A new request may be accepted in the cycle a lookup completes. A read that immediately follows a write hit to the same word returns the newly written data.
- R10: A line in the same set under a different physical page number does not hit. The read misses and refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| tlb_hit | input | 1 | Translation valid, one cycle after accept or later |
| tlb_ppn | input | 19 | Translated physical page number |
| resp_valid | output | 1 | Lookup finished |
| resp_hit | output | 1 | Lookup found the line |
| resp_rdata | output | 32 | Read data |
| wt_valid | output | 1 | Write-through to next level |
| wt_paddr | output | 32 | Write-through physical address |
| wt_wdata | output | 32 | Write-through data |
| fill_req | output | 1 | Line request to next level |
| fill_paddr | output | 32 | Line-aligned physical address |
| fill_beat_valid | input | 1 | Refill word present |
| fill_beat_data | input | 32 | Refill word |

## Verification
Reads and writes are issued with the translation arriving at once and with stalls of one to three cycles. This separates a correct hold from a compare that fires early on a stale page number. Aliased virtual addresses with one page offset are mapped to one page, which shows that the index ignores translated bits. The same set is also mapped under two different page numbers, which shows that the tag is physical. A write hit followed at once by a read of the same word, and a write miss followed by a read, separate forwarding, update and no-allocate behaviour. An invalidate between hits shows that the valid state is cleared.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_FREQ = 3'd2,
    ST_FILL = 3'd3,
    ST_DONE = 3'd4
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SET_W = 7,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             valid_any
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_mem [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (clr_all) vld_q <= '0;
    else if (wr_en)   vld_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tag   <= '0;
    end else begin
      if (clr_all)    rd_valid <= 1'b0;
      else if (rd_en) rd_valid <= vld_q[rd_set];
      if (rd_en)      rd_tag   <= tag_mem[rd_set];
    end
  end

  assign valid_any = |vld_q;
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int AW     = 11,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              fwd_hit
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  assign fwd_hit = wr_en && rd_en && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= fwd_hit ? wr_data : mem[rd_addr];
  end
endmodule

// File: rtl/vipt_refill_seq.sv
module vipt_refill_seq #(
  parameter int WIDX_W = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              beat_valid,
  input  logic [WORD_W-1:0] beat_data,
  input  logic [WIDX_W-1:0] want_idx,
  output logic [WIDX_W-1:0] beat_idx,
  output logic              last_beat,
  output logic [WORD_W-1:0] cap_word
);
  logic take;

  assign take      = active && beat_valid;
  assign last_beat = take && (&beat_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)     beat_idx <= '0;
    else if (start) beat_idx <= '0;
    else if (take)  beat_idx <= beat_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            cap_word <= '0;
    else if (take && beat_idx == want_idx) cap_word <= beat_data;
  end
endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 128,
  parameter int PAGE_BYTES = 8192
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                inval_all,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [VA_W-1:0]                     req_vaddr,
  input  logic [WORD_W-1:0]                   req_wdata,
  input  logic                                tlb_hit,
  input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]  tlb_ppn,
  output logic                                resp_valid,
  output logic                                resp_hit,
  output logic [WORD_W-1:0]                   resp_rdata,
  output logic                                wt_valid,
  output logic [PA_W-1:0]                     wt_paddr,
  output logic [WORD_W-1:0]                   wt_wdata,
  output logic                                fill_req,
  output logic [PA_W-1:0]                     fill_paddr,
  input  logic                                fill_beat_valid,
  input  logic [WORD_W-1:0]                   fill_beat_data
);
  localparam int BYTE_OFF   = $clog2(WORD_W / 8);
  localparam int LINE_OFF   = $clog2(LINE_BYTES);
  localparam int LINE_WORDS = LINE_BYTES / (WORD_W / 8);
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int SET_W      = $clog2(SETS);
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int PPN_W      = PA_W - PAGE_W;
  localparam int IDX_TOP    = LINE_OFF + SET_W;
  localparam int TAG_W      = PA_W - IDX_TOP;
  localparam int DADDR_W    = SET_W + WIDX_W;

  // address arithmetic, kept in functions so each slice is named once
  function automatic logic [SET_W-1:0] set_of(input logic [VA_W-1:0] va);
    return SET_W'(va >> LINE_OFF);
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [VA_W-1:0] va);
    return WIDX_W'(va >> BYTE_OFF);
  endfunction

  function automatic logic [PA_W-1:0] phys_of(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0]  va);
    return {ppn, PAGE_W'(va)};
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PA_W-1:0] pa);
    return TAG_W'(pa >> IDX_TOP);
  endfunction

  function automatic logic [PA_W-1:0] line_of(input logic [PA_W-1:0] pa);
    return pa & ~(PA_W'(LINE_BYTES - 1));
  endfunction

  vipt_state_e st_q, st_d;

  logic [VA_W-1:0]   s2_va_q;
  logic              s2_wr_q;
  logic [WORD_W-1:0] s2_wd_q;
  logic [PPN_W-1:0]  s2_ppn_q;

  // named internal events
  logic              accept;
  logic              lookup_pend;
  logic              cmp_fire;
  logic              tag_match;
  logic              complete;
  logic              fill_busy;
  logic              fill_start;
  logic              write_hit;
  logic              valid_any;
  logic              fwd_hit;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [WORD_W-1:0] rd_word;
  logic [WIDX_W-1:0] beat_idx;
  logic              last_beat;
  logic [WORD_W-1:0] cap_word;

  logic              dwr_en;
  logic [DADDR_W-1:0] dwr_addr;
  logic [WORD_W-1:0] dwr_data;

  assign lookup_pend = (st_q == ST_LOOK);
  assign fill_busy   = (st_q == ST_FILL);
  assign fill_start  = (st_q == ST_FREQ);
  assign cmp_fire    = lookup_pend && tlb_hit;
  assign tag_match   = rd_valid && (rd_tag == tag_of(phys_of(tlb_ppn, s2_va_q)));
  assign complete    = cmp_fire && (tag_match || s2_wr_q);
  assign write_hit   = cmp_fire && s2_wr_q && tag_match;

  assign req_ready   = (st_q == ST_IDLE) || (st_q == ST_DONE) || complete;
  assign accept      = req_valid && req_ready;

  assign dwr_en   = write_hit || (fill_busy && fill_beat_valid);
  assign dwr_addr = fill_busy ? {set_of(s2_va_q), beat_idx}
                              : {set_of(s2_va_q), word_of(s2_va_q)};
  assign dwr_data = fill_busy ? fill_beat_data : s2_wd_q;

  vipt_tag_store #(
    .SET_W (SET_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (inval_all),
    .rd_en     (accept),
    .rd_set    (set_of(req_vaddr)),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .wr_en     (last_beat),
    .wr_set    (set_of(s2_va_q)),
    .wr_tag    (tag_of(phys_of(s2_ppn_q, s2_va_q))),
    .valid_any (valid_any)
  );

  vipt_data_store #(
    .AW     (DADDR_W),
    .WORD_W (WORD_W)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (accept),
    .rd_addr ({set_of(req_vaddr), word_of(req_vaddr)}),
    .rd_data (rd_word),
    .wr_en   (dwr_en),
    .wr_addr (dwr_addr),
    .wr_data (dwr_data),
    .fwd_hit (fwd_hit)
  );

  vipt_refill_seq #(
    .WIDX_W (WIDX_W),
    .WORD_W (WORD_W)
  ) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fill_start),
    .active     (fill_busy),
    .beat_valid (fill_beat_valid),
    .beat_data  (fill_beat_data),
    .want_idx   (word_of(s2_va_q)),
    .beat_idx   (beat_idx),
    .last_beat  (last_beat),
    .cap_word   (cap_word)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: st_d = accept ? ST_LOOK : ST_IDLE;
      ST_LOOK: begin
        if (cmp_fire) begin
          if (complete) st_d = accept ? ST_LOOK : ST_IDLE;
          else          st_d = ST_FREQ;
        end
      end
      ST_FREQ: st_d = ST_FILL;
      ST_FILL: if (last_beat) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      s2_va_q  <= '0;
      s2_wr_q  <= 1'b0;
      s2_wd_q  <= '0;
      s2_ppn_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        s2_va_q <= req_vaddr;
        s2_wr_q <= req_write;
        s2_wd_q <= req_wdata;
      end
      if (cmp_fire) s2_ppn_q <= tlb_ppn;
    end
  end

  assign resp_valid = complete || (st_q == ST_DONE);
  assign resp_hit   = complete && tag_match;
  assign resp_rdata = (st_q == ST_DONE) ? cap_word : rd_word;

  assign wt_valid   = cmp_fire && s2_wr_q;
  assign wt_paddr   = phys_of(tlb_ppn, s2_va_q);
  assign wt_wdata   = s2_wd_q;

  assign fill_req   = fill_start;
  assign fill_paddr = line_of(phys_of(s2_ppn_q, s2_va_q));
endmodule

// File: rtl/vipt_l1_cache_chk.sv
module vipt_l1_cache_chk #(
  parameter int LINE_OFF = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inval_all,
  input logic                req_ready,
  input logic                tlb_hit,
  input logic                resp_valid,
  input logic                resp_hit,
  input logic                wt_valid,
  input logic                fill_req,
  input logic [LINE_OFF-1:0] fill_off,
  input logic                lookup_pend,
  input logic                fill_busy,
  input logic                valid_any
);
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !valid_any); // R1

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_pend && !tlb_hit) |-> (!resp_valid && !fill_req && !wt_valid && !req_ready)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_pend && !tlb_hit) |=> lookup_pend); // R3

  AST_HIT_NEEDS_TLB: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> tlb_hit); // R4

  AST_FILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> (!fill_req && fill_busy)); // R6

  AST_FILL_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (fill_off == '0)); // R6

  AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> (!req_ready && !resp_valid)); // R7

  AST_WT_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> resp_valid); // R8
endmodule

bind vipt_l1_cache vipt_l1_cache_chk #(.LINE_OFF(LINE_OFF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inval_all   (inval_all),
  .req_ready   (req_ready),
  .tlb_hit     (tlb_hit),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .wt_valid    (wt_valid),
  .fill_req    (fill_req),
  .fill_off    (fill_paddr[LINE_OFF-1:0]),
  .lookup_pend (lookup_pend),
  .fill_busy   (fill_busy),
  .valid_any   (valid_any)
);

// File: tb/vipt_l1_cache_tb.sv
`timescale 1ns/100ps
module vipt_l1_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inval_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic        tlb_hit = 1'b0;
  logic [18:0] tlb_ppn = '0;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        wt_valid;
  logic [31:0] wt_paddr, wt_wdata;
  logic        fill_req;
  logic [31:0] fill_paddr;
  logic        fill_beat_valid = 1'b0;
  logic [31:0] fill_beat_data = '0;

  int total = 0;
  int bad   = 0;

  // behavioural reference: per-set line state plus a sparse next-level memory
  bit          m_valid [128];
  logic [18:0] m_page  [128];
  logic [31:0] m_word  [128][16];
  logic [31:0] backmem [int unsigned];

  always #2.5 clk = ~clk;

  vipt_l1_cache u_dut (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .wt_valid(wt_valid), .wt_paddr(wt_paddr), .wt_wdata(wt_wdata),
    .fill_req(fill_req), .fill_paddr(fill_paddr),
    .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data)
  );

  function automatic logic [31:0] next_level(input logic [31:0] pa);
    if (backmem.exists(pa)) return backmem[pa];
    return (pa * 32'd2654435761) ^ 32'h0F1E_2D3C;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // one access; tag names the requirement that the lookup outcome exercises
  task automatic access(input logic [31:0] va, input bit wr, input logic [31:0] wd,
                        input logic [18:0] ppn, input int stall, input string tag);
    int          set_i, wrd;
    logic [31:0] pa, line;
    bit          hit;
    set_i = int'(va[12:6]);
    wrd   = int'(va[5:2]);
    pa    = {ppn, va[12:0]};
    line  = {ppn, va[12:6], 6'b0};
    @(negedge clk);
    check("R9", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd; tlb_hit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int s = 0; s < stall; s++) begin
      tlb_hit = 1'b0; tlb_ppn = ~ppn;
      #1;
      check("R3", "resp during stall", resp_valid, 0);
      check("R3", "fill during stall", fill_req, 0);
      check("R3", "wt during stall", wt_valid, 0);
      check("R3", "ready during stall", req_ready, 0);
      @(negedge clk);
    end
    tlb_hit = 1'b1; tlb_ppn = ppn;
    #1;
    hit = m_valid[set_i] && (m_page[set_i] == ppn);
    if (wr) begin
      check("R8", "write resp_valid", resp_valid, 1);
      check("R8", "write resp_hit", resp_hit, hit);
      check("R8", "wt_valid", wt_valid, 1);
      check("R8", "wt_paddr", wt_paddr, pa);
      check("R8", "wt_wdata", wt_wdata, wd);
      backmem[pa] = wd;
      if (hit) m_word[set_i][wrd] = wd;
      @(negedge clk);
      tlb_hit = 1'b0;
    end else if (hit) begin
      check(tag, "hit resp_valid", resp_valid, 1);
      check(tag, "hit resp_hit", resp_hit, 1);
      check(tag, "hit data", resp_rdata, m_word[set_i][wrd]);
      check(tag, "no wt on read", wt_valid, 0);
      @(negedge clk);
      tlb_hit = 1'b0;
    end else begin
      check(tag, "miss no resp at compare", resp_valid, 0);
      check("R6", "fill not yet", fill_req, 0);
      @(negedge clk);
      tlb_hit = 1'b0;
      #1;
      check("R6", "fill_req", fill_req, 1);
      check("R6", "fill_paddr", fill_paddr, line);
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        fill_beat_valid = 1'b1;
        fill_beat_data  = next_level(line + 32'(4 * b));
        #1;
        check("R7", "no resp during refill", resp_valid, 0);
        check("R7", "no accept during refill", req_ready, 0);
        if (b == 0) check("R6", "fill pulse ended", fill_req, 0);
      end
      @(negedge clk);
      fill_beat_valid = 1'b0;
      #1;
      check("R7", "refill resp_valid", resp_valid, 1);
      check("R7", "refill resp_hit", resp_hit, 0);
      check("R7", "refill data", resp_rdata, next_level({pa[31:2], 2'b00}));
      m_valid[set_i] = 1'b1;
      m_page[set_i]  = ppn;
      for (int b = 0; b < 16; b++) m_word[set_i][b] = next_level(line + 32'(4 * b));
    end
  endtask

  // write hit followed in the very next cycle by a read of the same word
  task automatic write_then_read(input logic [31:0] va, input logic [31:0] wd,
                                 input logic [18:0] ppn);
    int set_i, wrd;
    set_i = int'(va[12:6]);
    wrd   = int'(va[5:2]);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = va; req_wdata = wd; tlb_hit = 1'b0;
    @(negedge clk);
    req_write = 1'b0; tlb_hit = 1'b1; tlb_ppn = ppn;
    #1;
    check("R9", "write completes", resp_valid, 1);
    check("R9", "write hit", resp_hit, 1);
    check("R9", "accept in completing cycle", req_ready, 1);
    check("R8", "wt_valid in pair", wt_valid, 1);
    backmem[{ppn, va[12:0]}] = wd;
    m_word[set_i][wrd] = wd;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R9", "read resp_valid", resp_valid, 1);
    check("R9", "read resp_hit", resp_hit, 1);
    check("R9", "read sees new data", resp_rdata, wd);
    @(negedge clk);
    tlb_hit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_valid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset ready", req_ready, 1);
    check("R1", "reset resp", resp_valid, 0);
    check("R1", "reset fill", fill_req, 0);
    check("R1", "reset wt", wt_valid, 0);

    access(32'h0000_1040, 0, 0, 19'h12345, 0, "R1");          // cold miss
    access(32'h0000_1040, 0, 0, 19'h12345, 0, "R4");          // hit
    access(32'h0000_1048, 0, 0, 19'h12345, 0, "R2");          // other word, same line
    access(32'hABCD_F048, 0, 0, 19'h12345, 0, "R5");          // alias, same offset
    access(32'h5555_3048, 0, 0, 19'h12345, 2, "R5");          // another alias, stalled
    access(32'h0000_1048, 0, 0, 19'h12345, 3, "R3");          // stalled hit
    access(32'h0000_1040, 0, 0, 19'h00777, 1, "R10");         // other page, same set
    access(32'h0000_1040, 0, 0, 19'h12345, 0, "R10");         // back again: miss
    access(32'h0000_1044, 1, 32'hDEAD_BEEF, 19'h12345, 0, "R8"); // write hit
    access(32'h0000_1044, 0, 0, 19'h12345, 0, "R8");          // read updated word
    access(32'h0000_0200, 1, 32'h1234_5678, 19'h00042, 1, "R8"); // write miss
    access(32'h0000_0200, 0, 0, 19'h00042, 0, "R8");          // no allocate: miss
    write_then_read(32'h0000_104C, 32'hCAFE_F00D, 19'h12345);
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    for (int i = 0; i < 128; i++) m_valid[i] = 1'b0;
    access(32'h0000_1040, 0, 0, 19'h12345, 0, "R1");          // miss after invalidate
    for (int i = 0; i < 6; i++)
      access(32'(i * 64 + 4 * i), 0, 0, 19'(19'h00100 + i), i % 3, "R2");
    for (int i = 0; i < 6; i++)
      access(32'(i * 64 + 4 * i), 0, 0, 19'(19'h00100 + i), (i + 1) % 3, "R4");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule